// File: doc/BRIEF.md
# Peripheral Chip Select Decoder

This block turns addresses on a multiplexed address/data bus into a small set of active-low chip selects for peripherals. The peripherals share one contiguous block of address space. The block begins at a programmable base address. Configuration chooses whether it lives in I/O space or memory space. The block is divided into equal 256-byte regions, one per select, laid out upward from the base. The lowest region drives select 0, the next drives select 1, and so on.

An address is decoded in the cycle where the address-phase strobe is high. The matching select goes low on the next clock edge and stays low until the end-of-cycle strobe is seen. Every select is forced high while bus hold is active and while reset is active. The upper two selects share their pins with the flow-control signals of serial port 1. While flow control for that port is enabled, those two selects are held inactive.

The outputs come straight from flip-flops, so a glitch in the decode never reaches a pin. The base and space settings are written through a one-cycle write strobe. A new setting first applies to an address phase in the cycle after the write.

Top module: `periph_cs_decoder`

## Requirements
- R1: While rst_n is low every bit of cs_n is 1. After reset the base register is 0 and the block sits in I/O space, so an I/O address phase at 0x00100 drives cs_n[1] low.
- R2: An address phase (ale=1) whose address lies inside the block drives cs_n[k] low at the next clock edge, where k = addr[9:8]. All other bits stay 1. The block spans 1 KB beginning at {base, 10'b0}.
- R3: An address phase matches only when its space bit (is_io: 1 = I/O, 0 = memory) equals the configured space bit.
- R4: An address phase outside the block, including the first byte above it and the last byte below it, leaves or returns every bit of cs_n at 1 at the next edge.
- R5: An asserted select stays low while neither ale, cyc_end nor hold is high. When cyc_end is sampled high without ale, every select is 1 at the next edge.
- R6: When hold is sampled high, every select is 1 at the next edge, and an address phase in that cycle is ignored.
- R7: When fc_en is sampled high, cs_n[3] and cs_n[2] are 1 at the next edge, while cs_n[1:0] keep decoding normally.
- R8: A configuration write (cfg_we=1) loads cfg_base and cfg_io at the edge. An address phase in the write cycle still uses the old setting, and one in the following cycle uses the new setting.
- R9: At most one bit of cs_n is 0 at any time.
- R10: A new address phase during an active select replaces it at the next edge with the decode of the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Bus address, valid while ale is high |
| is_io | input | 1 | Space of the current access: 1 = I/O, 0 = memory |
| ale | input | 1 | Address-phase strobe |
| cyc_end | input | 1 | End-of-cycle strobe |
| hold | input | 1 | Bus hold active |
| fc_en | input | 1 | Serial port 1 hardware flow control enabled |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_base | input | 10 | New base, as address bits 19:10 |
| cfg_io | input | 1 | New space bit: 1 = I/O, 0 = memory |
| cs_n | output | 4 | Active-low peripheral selects |

## Verification
The bench aims at the edges of the block: offsets 0x0FF and 0x100 inside it, the bytes just below and just above it, and an access in the wrong space. A design with an off-by-one or an unmasked compare would assert a select there. It tests a configuration write with an address phase in the same cycle and in the next cycle, which exposes a decode that reads the write data too early or too late. It raises hold and flow control in the middle of an active select, and it issues an address phase during hold. A design that only masks the outputs, or that keeps the old state underneath, would bring back a stale select or decode while the bus is released. Back-to-back address phases with no end strobe between them catch a design that holds on to the first select.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    localparam int unsigned DEF_ADDR_W      = 20;
    localparam int unsigned DEF_REGION_BITS = 8;
    localparam int unsigned DEF_NUM_SEL     = 4;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
    import cs_pkg::*;
#(
    parameter int unsigned BASE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic              cfg_io,
    output logic [BASE_W-1:0] base_q,
    output space_e            space_q
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
        space_e            space;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.base  = cfg_base;
            cfg_d.space = space_e'(cfg_io);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.base  <= '0;
            cfg_q.space <= SPACE_IO;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign base_q  = cfg_q.base;
    assign space_q = cfg_q.space;

    // R8: a write is visible one edge later
    p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (base_q == $past(cfg_base)) && (space_q == space_e'($past(cfg_io))));
endmodule

// File: rtl/cs_addr_match.sv
module cs_addr_match
    import cs_pkg::*;
#(
    parameter int unsigned ADDR_W      = 20,
    parameter int unsigned REGION_BITS = 8,
    parameter int unsigned NUM_SEL     = 4,
    localparam int unsigned SEL_W      = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
    localparam int unsigned BLOCK_BITS = REGION_BITS + SEL_W,
    localparam int unsigned BASE_W     = ADDR_W - BLOCK_BITS
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               is_io,
    input  logic [BASE_W-1:0]  base,
    input  space_e             space,
    output logic [NUM_SEL-1:0] hit
);
    logic             blk_hit;
    logic [SEL_W-1:0] region;

    always_comb begin
        blk_hit = (addr[ADDR_W-1:BLOCK_BITS] == base) && (space_e'(is_io) == space);
        region  = addr[BLOCK_BITS-1:REGION_BITS];
    end

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_region
        assign hit[i] = blk_hit && (region == SEL_W'(i));
    end
endmodule

// File: rtl/cs_sel_state.sv
module cs_sel_state #(
    parameter int unsigned          NUM_SEL     = 4,
    parameter logic [NUM_SEL-1:0]   FC_SEL_MASK = 4'b1100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ale,
    input  logic               cyc_end,
    input  logic               hold,
    input  logic               fc_en,
    input  logic [NUM_SEL-1:0] hit,
    output logic [NUM_SEL-1:0] cs_n
);
    typedef struct packed {
        logic [NUM_SEL-1:0] act;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (hold) begin
            sel_d.act = '0;
        end else if (ale) begin
            sel_d.act = hit;
        end else if (cyc_end) begin
            sel_d.act = '0;
        end
        if (fc_en) begin
            sel_d.act = sel_d.act & ~FC_SEL_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q.act <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign cs_n = ~sel_q.act;

    // R9
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R6
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (&cs_n));
    // R7
    p_fc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fc_en |=> (&(cs_n | ~FC_SEL_MASK)));
    // R5 release
    p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !ale) |=> (&cs_n));
    // R5 keep
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !cyc_end && !hold && !fc_en) |=> $stable(cs_n));
endmodule

// File: rtl/periph_cs_decoder.sv
module periph_cs_decoder
    import cs_pkg::*;
#(
    parameter int unsigned        ADDR_W      = DEF_ADDR_W,
    parameter int unsigned        REGION_BITS = DEF_REGION_BITS,
    parameter int unsigned        NUM_SEL     = DEF_NUM_SEL,
    parameter logic [NUM_SEL-1:0] FC_SEL_MASK = 4'b1100,
    localparam int unsigned       SEL_W       = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
    localparam int unsigned       BLOCK_BITS  = REGION_BITS + SEL_W,
    localparam int unsigned       BASE_W      = ADDR_W - BLOCK_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               is_io,
    input  logic               ale,
    input  logic               cyc_end,
    input  logic               hold,
    input  logic               fc_en,
    input  logic               cfg_we,
    input  logic [BASE_W-1:0]  cfg_base,
    input  logic               cfg_io,
    output logic [NUM_SEL-1:0] cs_n
);
    logic [BASE_W-1:0]  base_q;
    space_e             space_q;
    logic [NUM_SEL-1:0] hit;

    cs_cfg_regs #(.BASE_W(BASE_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_base (cfg_base),
        .cfg_io   (cfg_io),
        .base_q   (base_q),
        .space_q  (space_q)
    );

    cs_addr_match #(
        .ADDR_W      (ADDR_W),
        .REGION_BITS (REGION_BITS),
        .NUM_SEL     (NUM_SEL)
    ) i_match (
        .addr  (addr),
        .is_io (is_io),
        .base  (base_q),
        .space (space_q),
        .hit   (hit)
    );

    cs_sel_state #(
        .NUM_SEL     (NUM_SEL),
        .FC_SEL_MASK (FC_SEL_MASK)
    ) i_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale     (ale),
        .cyc_end (cyc_end),
        .hold    (hold),
        .fc_en   (fc_en),
        .hit     (hit),
        .cs_n    (cs_n)
    );

    // R2: a decoded hit shows on the pins one edge later
    p_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !hold && !fc_en && (hit != '0)) |=> ((~cs_n) == $past(hit)));
    // R4: a miss leaves every select inactive
    p_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !hold && (hit == '0)) |=> (&cs_n));
endmodule

// File: tb/test_periph_cs_decoder.sv
module test_periph_cs_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        is_io = 1'b0;
    logic        ale = 1'b0;
    logic        cyc_end = 1'b0;
    logic        hold = 1'b0;
    logic        fc_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_base = '0;
    logic        cfg_io = 1'b0;
    logic [3:0]  cs_n;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference state
    int exp_sel = -1;
    int exp_base = 0;
    int exp_io = 1;

    always #5 clk = ~clk;

    periph_cs_decoder i_periph_cs_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .is_io(is_io), .ale(ale),
        .cyc_end(cyc_end), .hold(hold), .fc_en(fc_en), .cfg_we(cfg_we),
        .cfg_base(cfg_base), .cfg_io(cfg_io), .cs_n(cs_n)
    );

    function automatic logic [3:0] exp_pins();
        logic [3:0] v = 4'hF;
        if (exp_sel >= 0) v[exp_sel] = 1'b0;
        return v;
    endfunction

    // behavioural model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_sel = -1; exp_base = 0; exp_io = 1;
        end else begin
            int nxt = exp_sel;
            if (hold) nxt = -1;
            else if (ale) begin
                if ((int'(is_io) == exp_io) && (int'(addr) / 1024 == exp_base))
                    nxt = (int'(addr) % 1024) / 256;
                else nxt = -1;
            end else if (cyc_end) nxt = -1;
            if (fc_en && nxt >= 2) nxt = -1;
            exp_sel = nxt;
            if (cfg_we) begin
                exp_base = int'(cfg_base);
                exp_io = int'(cfg_io);
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        checks++;
        if (cs_n !== exp_pins()) begin
            fails++;
            $display("FAIL %s: cs_n=%b expected %b at cycle %0d", cur_req, cs_n, exp_pins(), cycles);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            finish_run();
        end
    end

    task automatic step(input logic [19:0] a, input logic io, input logic al,
                        input logic ce, input logic h, input logic fc);
        @(negedge clk); #1;
        addr = a; is_io = io; ale = al; cyc_end = ce; hold = h; fc_en = fc;
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(addr, is_io, 1'b0, 1'b0, 1'b0, fc_en);
    endtask

    task automatic cfg(input logic [9:0] b, input logic io);
        @(negedge clk); #1;
        ale = 1'b0; cyc_end = 1'b0; hold = 1'b0;
        cfg_we = 1'b1; cfg_base = b; cfg_io = io;
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        // R1: reset with an address phase that would otherwise hit
        cur_req = "R1";
        addr = 20'h00100; is_io = 1'b1; ale = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1; ale = 1'b0;
        step(20'h00100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(2);
        step(20'h00100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

        // R2: all four regions, memory space, base 0x2A
        cur_req = "R2";
        cfg(10'h2A, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step({10'h2A, 2'(k), 8'h00}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
            idle(1);
            step(addr, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        end
        // region edges 0x0FF and 0x100
        step({10'h2A, 10'h0FF}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step({10'h2A, 10'h100}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step({10'h2A, 10'h3FF}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step(addr, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R3: wrong space
        cur_req = "R3";
        step({10'h2A, 10'h100}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(2);

        // R4: just outside the block
        cur_req = "R4";
        step({10'h2B, 10'h000}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step({10'h29, 10'h3FF}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(1);
        step({10'h2A, 10'h000}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step({10'h2B, 10'h000}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(1);

        // R5: hold select across idle cycles, release on cyc_end
        cur_req = "R5";
        step({10'h2A, 10'h200}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(5);
        step(addr, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        idle(2);

        // R6: bus hold mid select, and address phase during hold
        cur_req = "R6";
        step({10'h2A, 10'h100}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(1);
        step(addr, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        step({10'h2A, 10'h000}, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        step(addr, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        idle(2);

        // R7: flow control masks selects 3 and 2 only
        cur_req = "R7";
        step({10'h2A, 10'h300}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        step({10'h2A, 10'h200}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        step({10'h2A, 10'h000}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        step({10'h2A, 10'h100}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        step(addr, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        step({10'h2A, 10'h300}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(1);
        step(addr, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        step(addr, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        idle(2);

        // R8: config write timing
        cur_req = "R8";
        @(negedge clk); #1;
        ale = 1'b1; addr = {10'h2A, 10'h100}; is_io = 1'b0; cyc_end = 1'b0;
        cfg_we = 1'b1; cfg_base = 10'h155; cfg_io = 1'b1;
        step({10'h2A, 10'h100}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step({10'h155, 10'h300}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        step(addr, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

        // R10: back-to-back address phases
        cur_req = "R10";
        step({10'h155, 10'h000}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        step({10'h155, 10'h200}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        step({10'h155, 10'h100}, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        step(addr, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

        // R9 and R2: pseudo-random traffic near the block
        cur_req = "R9";
        for (int n = 0; n < 2000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step({(lfsr[3] ? 10'h155 : 10'h154), lfsr[15:6]}, lfsr[4] | lfsr[5],
                 lfsr[0], lfsr[1], (lfsr[2] & lfsr[11]), (lfsr[9] & lfsr[8]));
        end
        idle(2);
        finish_run();
    end
endmodule